// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multiple-register load or store request into a stream of single-word transfer beats. A request gives a 32-bit base address, a 16-bit mask of selected registers, and four control bits: pre/post indexing, up/down direction, load/store and base write-back. For each selected register the block issues one beat with the register index, the word address and the direction. After the last beat it pulses done and reports the updated base value together with a write-back enable.

The direction and indexing bits select one of four address modes: increment-after, increment-before, decrement-after and decrement-before. Stack-style operations reach these modes through the direction and indexing bits. For a full-descending load or an empty-ascending store the caller sets post-indexing and up. For an empty-descending load or a full-ascending store it sets pre-indexing and up. For an empty-ascending load or a full-descending store it sets pre-indexing and down. For a full-ascending load or an empty-descending store it sets post-indexing and down. Registers always go out in ascending index order, and the lowest index always gets the lowest address. Beats advance one per clock while the consumer is ready.

Top module: `blk_xfer_seq`

## Requirements
- R1: With up_dir=1 and pre_idx=0 (increment-after), the k-th beat (k from 0) carries address base_addr + 4k.
- R2: With up_dir=1 and pre_idx=1 (increment-before), the k-th beat carries address base_addr + 4 + 4k.
- R3: With up_dir=0 and pre_idx=0 (decrement-after), the first beat carries base_addr − 4n + 4, where n is the number of set mask bits, and each following beat adds 4.
- R4: With up_dir=0 and pre_idx=1 (decrement-before), the first beat carries base_addr − 4n, and each following beat adds 4.
- R5: One beat is issued for each set bit of reg_mask, including masks with gaps, in ascending register index order. beat_reg carries the 4-bit index, and the addresses rise by 4 from beat to beat.
- R6: beat_load equals the is_load value captured at start (1 = load, 0 = store) on every beat of the request.
- R7: In the done cycle, wb_base is base_addr + 4n when up_dir=1 and base_addr − 4n when up_dir=0. wb_we is 1 only when wb_req=1 and n>0, and wb_we is never 1 outside a done cycle.
- R8: When reg_mask is all zero, no beat is issued. done pulses in the cycle after start is accepted, and wb_we stays 0.
- R9: While beat_valid=1 and beat_ready=0, beat_valid, beat_reg, beat_addr and beat_load hold their values into the next cycle.
- R10: done is a one-cycle pulse. It comes in the cycle after the last beat is accepted and never at the same time as beat_valid. A start asserted while a request is in progress is ignored.
- R11: After reset, beat_valid, done and wb_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| base_addr | input | 32 | Base address of the request |
| reg_mask | input | 16 | Selected registers, bit i = register i |
| pre_idx | input | 1 | 1 = step before the transfer, 0 = step after |
| up_dir | input | 1 | 1 = increment, 0 = decrement |
| is_load | input | 1 | 1 = load, 0 = store |
| wb_req | input | 1 | Request write-back of the updated base |
| beat_valid | output | 1 | A transfer beat is presented |
| beat_ready | input | 1 | The consumer takes the beat this cycle |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| beat_load | output | 1 | Direction of the beat, 1 = load |
| done | output | 1 | One-cycle end-of-request pulse |
| wb_we | output | 1 | Write-back enable, valid with done |
| wb_base | output | 32 | Updated base value, valid with done |

## Verification
The assertions rely on the consumer seeing each beat through the valid/ready handshake. They also rely on a new request starting only after the previous done, so that two requests never run back to back without an idle cycle between them. The bench keeps to this by pulsing start only from idle. The one exception is a deliberate extra start in the middle of a request, which the design must ignore. The stimulus drives beat_ready in three patterns: always high, alternating, and random. Together these cover the stall behaviour of every address mode, with gapped masks, single-register masks, a full mask and an empty mask.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [NREG-1:0] reg_mask,
  input  logic          pre_idx,
  input  logic          up_dir,
  input  logic          is_load,
  input  logic          wb_req,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [RW-1:0] beat_reg,
  output logic [AW-1:0] beat_addr,
  output logic          beat_load,
  output logic          done,
  output logic          wb_we,
  output logic [AW-1:0] wb_base
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  function automatic logic [RW:0] pop_count(input logic [NREG-1:0] m);
    logic [RW:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + (RW+1)'(m[i]);
    return c;
  endfunction

  function automatic logic [RW-1:0] low_index(input logic [NREG-1:0] m);
    logic [RW-1:0] idx;
    idx = '0;
    for (int i = NREG-1; i >= 0; i--) if (m[i]) idx = RW'(i);
    return idx;
  endfunction

  state_t          state;
  logic [NREG-1:0] remain;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   final_q;
  logic            load_q;
  logic            wb_q;

  logic [AW-1:0] span;
  logic [AW-1:0] first_addr;
  logic          accept;
  logic          take;
  logic          last_beat;

  assign span       = AW'(pop_count(reg_mask)) * AW'(STEP);
  assign first_addr = up_dir ? (pre_idx ? base_addr + AW'(STEP) : base_addr)
                             : (pre_idx ? base_addr - span : base_addr - span + AW'(STEP));
  assign accept     = start && (state == S_IDLE);
  assign take       = beat_valid && beat_ready;
  assign last_beat  = (remain & (remain - 1'b1)) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      remain  <= '0;
      addr_q  <= '0;
      final_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          remain  <= reg_mask;
          addr_q  <= first_addr;
          final_q <= up_dir ? base_addr + span : base_addr - span;
          load_q  <= is_load;
          wb_q    <= wb_req && (reg_mask != '0);
          state   <= (reg_mask == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (take) begin
          remain <= remain & (remain - 1'b1);
          addr_q <= addr_q + AW'(STEP);
          if (last_beat) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign beat_valid = (state == S_RUN);
  assign beat_reg   = low_index(remain);
  assign beat_addr  = addr_q;
  assign beat_load  = load_q;
  assign done       = (state == S_FIN);
  assign wb_we      = done && wb_q;
  assign wb_base    = final_q;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int AW   = 32,
  parameter int RW   = 4,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [RW-1:0] beat_reg,
  input logic [AW-1:0] beat_addr,
  input logic          beat_load,
  input logic          done,
  input logic          wb_we
);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid && beat_ready)) |-> beat_addr == $past(beat_addr) + AW'(STEP)); // R5

  AST_REG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid && beat_ready)) |-> beat_reg > $past(beat_reg)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg) && $stable(beat_load))); // R9

  AST_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> $stable(beat_load)); // R6

  AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> done); // R7

  AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.AW(AW), .RW(RW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_reg(beat_reg), .beat_addr(beat_addr), .beat_load(beat_load),
  .done(done), .wb_we(wb_we)
);

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic        pre_idx = 1'b0, up_dir = 1'b0, is_load = 1'b0, wb_req = 1'b0;
  logic        beat_ready = 1'b0;
  logic        beat_valid, beat_load, done, wb_we;
  logic [3:0]  beat_reg;
  logic [31:0] beat_addr, wb_base;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  blk_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .reg_mask(reg_mask),
    .pre_idx(pre_idx), .up_dir(up_dir), .is_load(is_load), .wb_req(wb_req),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_reg(beat_reg),
    .beat_addr(beat_addr), .beat_load(beat_load), .done(done), .wb_we(wb_we),
    .wb_base(wb_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready patterns: 0 always, 1 alternating, 2 random
  task automatic run(input logic [31:0] b, input logic [15:0] m, input logic p, input logic u,
                     input logic l, input logic w, input int rmode, input bit poke);
    int regs[$];
    int n, tick;
    logic [31:0] a, fin;
    string tag;
    n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin regs.push_back(i); n++; end
    if (u) a = p ? b + 4 : b;
    else   a = p ? b - 32'(4*n) : b - 32'(4*n) + 4;
    fin = u ? b + 32'(4*n) : b - 32'(4*n);
    tag = u ? (p ? "R2" : "R1") : (p ? "R4" : "R3");
    @(negedge clk);
    base_addr = b; reg_mask = m; pre_idx = p; up_dir = u; is_load = l; wb_req = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tick = 0;
    while (regs.size() > 0) begin
      check("R5 valid", {31'b0, beat_valid}, 32'd1);
      check("R5 reg", {28'b0, beat_reg}, 32'(regs[0]));
      check(tag, beat_addr, a);
      check("R6 load", {31'b0, beat_load}, {31'b0, l});
      check("R10 no done", {31'b0, done}, 32'd0);
      if (poke && tick == 0) begin
        start = 1'b1; reg_mask = 16'hFFFF; up_dir = ~u;
      end else start = 1'b0;
      case (rmode)
        0: beat_ready = 1'b1;
        1: beat_ready = tick[0];
        default: beat_ready = 1'($urandom % 2);
      endcase
      @(negedge clk);
      if (beat_ready) begin
        void'(regs.pop_front());
        a = a + 4;
      end else if (regs.size() > 0) begin
        check("R9 hold", beat_addr, a);
      end
      beat_ready = 1'b0;
      start = 1'b0;
      tick++;
      if (tick > 200) break;
    end
    check("R10 done", {31'b0, done}, 32'd1);
    check(m == 0 ? "R8 no beat" : "R10 no beat", {31'b0, beat_valid}, 32'd0);
    check(m == 0 ? "R8 wb_we" : "R7 wb_we", {31'b0, wb_we}, {31'b0, (w && n > 0)});
    if (w && n > 0) check("R7 wb_base", wb_base, fin);
    @(negedge clk);
    check("R10 pulse", {31'b0, done}, 32'd0);
    check("R7 wb_we idle", {31'b0, wb_we}, 32'd0);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2;
    check("R11 valid", {31'b0, beat_valid}, 32'd0);
    check("R11 done", {31'b0, done}, 32'd0);
    check("R11 wb_we", {31'b0, wb_we}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 increment-after (full-descending load / empty-ascending store)
    run(32'h0000_1000, 16'b1010_0000_0100_0101, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run(32'h0000_2000, 16'h00F0, 1'b0, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    // R2 increment-before
    run(32'h0000_3000, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b0);
    run(32'h0000_3100, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b0);
    // R3 decrement-after
    run(32'h0000_4000, 16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b0);
    run(32'h0000_0004, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    // R4 decrement-before (full-descending store)
    run(32'h0000_5000, 16'h4112, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    run(32'h0000_5100, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    // R8 empty mask
    run(32'h0000_6000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run(32'h0000_6000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    // R10 start during a request is ignored
    run(32'h0000_7000, 16'h0C30, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    run(32'h0000_7100, 16'h0306, 1'b1, 1'b0, 1'b0, 1'b1, 2, 1'b1);
    for (int k = 0; k < 20; k++)
      run($urandom & 32'hFFFF_FFFC, 16'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 2, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule